// File: doc/BRIEF.md
# Packed-Lane ChaCha20 Keystream Block Engine

This block produces one 512-bit ChaCha20 keystream block (the variant with a 96-bit nonce and a 32-bit block counter) from a 256-bit key, a nonce and a counter. It forms the sixteen-word starting matrix and runs ten double rounds, each a column round followed by a diagonal round. It then adds the starting matrix back into the result, word by word and modulo 2^32. The working matrix lives in eight 64-bit registers. Each register carries two horizontally adjacent words of one row, with the lower-numbered word in bits 31:0. One packed two-lane step (an add, or an xor followed by a rotate) is done per clock. Eight such steps form a half-round, which advances two columns together. Two half-rounds form one round.

Diagonal rounds have no datapath of their own. At the end of every column round, row r of the matrix is rotated left by r word positions, so that the diagonals line up as columns. At the end of every diagonal round the rotation is undone. The block needs 321 cycles from acceptance to a valid output.

The input side is a valid/ready handshake: a request (key, nonce, counter) is taken on a clock edge where `in_valid` and `in_ready` are both high, and `in_ready` is high only while the engine is idle. The output side is also valid/ready: `out_valid` rises with the finished block and stays high, with `keystream` unchanged, until a clock edge where `out_ready` is high. Only after that does the engine return to idle and raise `in_ready`. Back-pressure on the output therefore stalls acceptance of the next request. `busy` is a plain status pin.

Top module: `chacha_lane_core`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `busy` is 0.
- R2: A request is taken only on an edge with `in_valid` and `in_ready` both high; while the engine is busy or holding a result, `in_ready` is 0 and changes on `key`, `nonce`, `blk_ctr` or `in_valid` have no effect on the result being computed.
- R3: Starting-matrix layout: words 0..3 are 0x61707865, 0x3320646E, 0x79622D32, 0x6B206574; words 4..11 are `key[32*i+:32]` for i = 0..7; word 12 is `blk_ctr`; words 13..15 are `nonce[32*j+:32]` for j = 0..2.
- R4: With key bytes 0x00..0x1F (byte n in `key[8n+:8]`), nonce words 0x09000000, 0x4A000000, 0x00000000 and counter 1, the output words are the published block test result (word 0 = 0xE4E7F110, word 15 = 0x4E3C50A2).
- R5: Output word i, at `keystream[32*i+:32]`, equals the result of 20 rounds (10 column/diagonal pairs, standard quarter-round with rotations 16, 12, 8, 7) plus starting word i modulo 2^32, for any key, nonce and counter, including all-zero and all-ones inputs.
- R6: `out_valid` first reads high 321 clock edges after the accepting edge.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `keystream` stays stable; on the edge where both are 1, `out_valid` falls and `in_ready` rises.
- R8: `busy` is 1 from the edge after acceptance until the result is valid, and 0 while idle or holding a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present on key/nonce/blk_ctr |
| in_ready | output | 1 | Engine idle, request can be taken |
| key | input | 256 | Key, word i at bits 32*i+31:32*i |
| nonce | input | 96 | Nonce, word j at bits 32*j+31:32*j |
| blk_ctr | input | 32 | Block counter |
| busy | output | 1 | Rounds or final addition in progress |
| out_valid | output | 1 | Keystream block valid |
| out_ready | input | 1 | Consumer takes the block |
| keystream | output | 512 | Keystream block, word i at bits 32*i+31:32*i |

## Verification
The bench goes after the re-packing between rounds: a wrong rotation direction or amount still gives some output, but not the published block result, and a design that undoes the packing one round late fails the all-zero and all-ones cases against the reference model. All-ones inputs make every final addition carry across each 32-bit lane; a design that lets the carry cross into the neighbouring lane, or drops the wrap, corrupts those words. A late or early step counter shows up as a latency different from 321 cycles. Changing the key while the engine is busy, and holding `out_ready` low, expose a design that keeps sampling its inputs or loses a block under back-pressure.

// File: rtl/chacha_lane_pkg.sv
package chacha_lane_pkg;
  localparam int WORD_W  = 32;
  localparam int LANES   = 2;
  localparam int PAIR_W  = WORD_W * LANES;
  localparam int ROWS    = 4;
  localparam int COLS    = 4;
  localparam int NWORDS  = ROWS * COLS;
  localparam int NPAIRS  = NWORDS / LANES;
  localparam int BLOCK_W = NWORDS * WORD_W;
  localparam int STEPS   = 8;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [PAIR_W-1:0] pair_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_FIN  = 2'd2,
    PH_HOLD = 2'd3
  } phase_e;

  localparam word_t SIGMA0 = 32'h61707865;
  localparam word_t SIGMA1 = 32'h3320646E;
  localparam word_t SIGMA2 = 32'h79622D32;
  localparam word_t SIGMA3 = 32'h6B206574;

  function automatic word_t rotl_word(word_t x, int amt);
    return (x << amt) | (x >> (WORD_W - amt));
  endfunction

  function automatic int rot_amount(logic [1:0] sel);
    case (sel)
      2'd0:    return 16;
      2'd1:    return 12;
      2'd2:    return 8;
      default: return 7;
    endcase
  endfunction
endpackage

// File: rtl/chacha_lane_alu.sv
module chacha_lane_alu
  import chacha_lane_pkg::*;
#(
  parameter int LN = LANES,
  parameter int WW = WORD_W
) (
  input  logic [LN*WW-1:0] dst_i,
  input  logic [LN*WW-1:0] src_i,
  input  logic             xr_i,
  input  logic [1:0]       rot_sel_i,
  output logic [LN*WW-1:0] res_o
);
  genvar g;
  generate
    for (g = 0; g < LN; g++) begin : g_lane
      logic [WW-1:0] a, b, sum, mix;
      assign a   = dst_i[g*WW +: WW];
      assign b   = src_i[g*WW +: WW];
      assign sum = a + b;
      assign mix = rotl_word(a ^ b, rot_amount(rot_sel_i));
      assign res_o[g*WW +: WW] = xr_i ? mix : sum;
    end
  endgenerate
endmodule

// File: rtl/chacha_row_rotate.sv
module chacha_row_rotate
  import chacha_lane_pkg::*;
#(
  parameter int NR = ROWS,
  parameter int NC = COLS,
  parameter int WW = WORD_W
) (
  input  logic [NR*NC*WW-1:0] state_i,
  input  logic                undo_i,
  output logic [NR*NC*WW-1:0] state_o
);
  localparam int ROW_W = NC * WW;
  genvar r;
  generate
    for (r = 0; r < NR; r++) begin : g_row
      localparam int FWD = r % NC;
      localparam int BWD = (NC - (r % NC)) % NC;
      logic [ROW_W-1:0]   row;
      logic [2*ROW_W-1:0] dbl;
      assign row = state_i[r*ROW_W +: ROW_W];
      assign dbl = {row, row};
      assign state_o[r*ROW_W +: ROW_W] =
        undo_i ? dbl[BWD*WW +: ROW_W] : dbl[FWD*WW +: ROW_W];
    end
  endgenerate
endmodule

// File: rtl/chacha_step_seq.sv
module chacha_step_seq
  import chacha_lane_pkg::*;
#(
  parameter int NROUNDS = 20,
  localparam int RND_W  = $clog2(NROUNDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             adv_i,
  output logic [2:0]       step_o,
  output logic             half_o,
  output logic [RND_W-1:0] round_o,
  output logic             round_end_o,
  output logic             last_o
);
  logic [2:0]       step_q;
  logic             half_q;
  logic [RND_W-1:0] round_q;

  assign step_o      = step_q;
  assign half_o      = half_q;
  assign round_o     = round_q;
  assign round_end_o = adv_i && (step_q == 3'd7) && half_q;
  assign last_o      = round_end_o && (round_q == RND_W'(NROUNDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      step_q  <= '0;
      half_q  <= 1'b0;
      round_q <= '0;
    end else if (adv_i) begin
      step_q <= step_q + 3'd1;
      if (step_q == 3'd7) half_q <= ~half_q;
      if (round_end_o)
        round_q <= last_o ? '0 : round_q + RND_W'(1);
    end
  end

  p_step_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !clear_i && step_q == 3'd7) |=> (step_q == 3'd0));
  p_half_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !clear_i && step_q == 3'd7) |=> (half_q != $past(half_q)));
  p_round_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    round_q < RND_W'(NROUNDS));
endmodule

// File: rtl/chacha_lane_core.sv
module chacha_lane_core
  import chacha_lane_pkg::*;
#(
  parameter int DOUBLE_ROUNDS = 10,
  parameter int KEY_W   = 256,
  parameter int NONCE_W = 96,
  parameter int CTR_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [KEY_W-1:0]   key,
  input  logic [NONCE_W-1:0] nonce,
  input  logic [CTR_W-1:0]   blk_ctr,
  output logic               busy,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [BLOCK_W-1:0] keystream
);
  localparam int NROUNDS = 2 * DOUBLE_ROUNDS;
  localparam int RND_W   = $clog2(NROUNDS);

  phase_e             phase_q;
  logic [BLOCK_W-1:0] init_q, work_q, out_q;
  logic [BLOCK_W-1:0] step_state, rot_state, next_state, sum_state;
  logic [2:0]         step;
  logic               half, round_end, last, accept, run;
  logic [RND_W-1:0]   round;
  logic [1:0]         dst_row, src_row;
  logic [2:0]         dst_idx, src_idx;
  pair_t              dst_pair, src_pair, res_pair;

  assign in_ready  = (phase_q == PH_IDLE);
  assign busy      = (phase_q == PH_RUN) || (phase_q == PH_FIN);
  assign out_valid = (phase_q == PH_HOLD);
  assign keystream = out_q;
  assign accept    = in_valid && in_ready;
  assign run       = (phase_q == PH_RUN);

  chacha_step_seq #(.NROUNDS(NROUNDS)) u_seq (
    .clk(clk), .rst_n(rst_n), .clear_i(accept), .adv_i(run),
    .step_o(step), .half_o(half), .round_o(round),
    .round_end_o(round_end), .last_o(last)
  );

  // step[1:0]: 0 A+=B, 1 D^=A, 2 C+=D, 3 B^=C ; odd steps rotate
  always_comb begin
    case (step[1:0])
      2'd0:    begin dst_row = 2'd0; src_row = 2'd1; end
      2'd1:    begin dst_row = 2'd3; src_row = 2'd0; end
      2'd2:    begin dst_row = 2'd2; src_row = 2'd3; end
      default: begin dst_row = 2'd1; src_row = 2'd2; end
    endcase
    dst_idx  = {dst_row, half};
    src_idx  = {src_row, half};
    dst_pair = work_q[dst_idx*PAIR_W +: PAIR_W];
    src_pair = work_q[src_idx*PAIR_W +: PAIR_W];
  end

  chacha_lane_alu u_alu (
    .dst_i(dst_pair), .src_i(src_pair), .xr_i(step[0]),
    .rot_sel_i(step[2:1]), .res_o(res_pair)
  );

  always_comb begin
    step_state = work_q;
    step_state[dst_idx*PAIR_W +: PAIR_W] = res_pair;
  end

  chacha_row_rotate u_rot (
    .state_i(step_state), .undo_i(round[0]), .state_o(rot_state)
  );

  assign next_state = round_end ? rot_state : step_state;

  genvar w;
  generate
    for (w = 0; w < NWORDS; w++) begin : g_fin
      assign sum_state[w*WORD_W +: WORD_W] =
        work_q[w*WORD_W +: WORD_W] + init_q[w*WORD_W +: WORD_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      init_q  <= '0;
      work_q  <= '0;
      out_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (accept) begin
          init_q  <= {nonce, blk_ctr, key, SIGMA3, SIGMA2, SIGMA1, SIGMA0};
          work_q  <= {nonce, blk_ctr, key, SIGMA3, SIGMA2, SIGMA1, SIGMA0};
          phase_q <= PH_RUN;
        end
        PH_RUN: begin
          work_q <= next_state;
          if (last) phase_q <= PH_FIN;
        end
        PH_FIN: begin
          out_q   <= sum_state;
          phase_q <= PH_HOLD;
        end
        default: if (out_ready) phase_q <= PH_IDLE;
      endcase
    end
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (busy && !in_ready));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(keystream)));
  p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready));
  p_busy_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(busy));
  p_init_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(init_q));
endmodule

// File: tb/sim_chacha_lane_core.sv
module sim_chacha_lane_core;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [255:0] key = '0;
  logic [95:0]  nonce = '0;
  logic [31:0]  blk_ctr = '0;
  logic         busy;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [511:0] keystream;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  chacha_lane_core u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .key(key), .nonce(nonce), .blk_ctr(blk_ctr), .busy(busy),
    .out_valid(out_valid), .out_ready(out_ready), .keystream(keystream)
  );

  function automatic logic [31:0] rl(logic [31:0] x, int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [127:0] qr(logic [127:0] v);
    logic [31:0] a, b, c, d;
    {d, c, b, a} = v;
    a = a + b; d = rl(d ^ a, 16);
    c = c + d; b = rl(b ^ c, 12);
    a = a + b; d = rl(d ^ a, 8);
    c = c + d; b = rl(b ^ c, 7);
    return {d, c, b, a};
  endfunction

  function automatic logic [511:0] ref_block(logic [255:0] k, logic [95:0] n, logic [31:0] ct);
    logic [31:0] s [16];
    logic [31:0] x [16];
    logic [511:0] r;
    int g [8][4] = '{'{0,4,8,12}, '{1,5,9,13}, '{2,6,10,14}, '{3,7,11,15},
                     '{0,5,10,15}, '{1,6,11,12}, '{2,7,8,13}, '{3,4,9,14}};
    s[0] = 32'h61707865; s[1] = 32'h3320646E; s[2] = 32'h79622D32; s[3] = 32'h6B206574;
    for (int i = 0; i < 8; i++) s[4+i] = k[32*i +: 32];
    s[12] = ct;
    for (int j = 0; j < 3; j++) s[13+j] = n[32*j +: 32];
    for (int i = 0; i < 16; i++) x[i] = s[i];
    for (int dr = 0; dr < 10; dr++)
      for (int q = 0; q < 8; q++) begin
        logic [127:0] t;
        t = qr({x[g[q][3]], x[g[q][2]], x[g[q][1]], x[g[q][0]]});
        {x[g[q][3]], x[g[q][2]], x[g[q][1]], x[g[q][0]]} = t;
      end
    for (int i = 0; i < 16; i++) r[32*i +: 32] = x[i] + s[i];
    return r;
  endfunction

  task automatic chk(bit ok, string req, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issue one request, return latency and captured block (out_ready stays as set).
  task automatic issue(logic [255:0] k, logic [95:0] n, logic [31:0] ct,
                       output int lat, output logic [511:0] blk);
    @(negedge clk);
    key = k; nonce = n; blk_ctr = ct; in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    lat = 0;
    do begin
      @(posedge clk); #1 lat++;
    end while (!out_valid && lat < 1000);
    blk = keystream;
  endtask

  task automatic t_reset();
    chk(in_ready === 1'b1, "R1 in_ready", 512'(in_ready), 512'(1));
    chk(out_valid === 1'b0, "R1 out_valid", 512'(out_valid), 512'(0));
    chk(busy === 1'b0, "R1 busy", 512'(busy), 512'(0));
  endtask

  task automatic t_vector();
    logic [255:0] k;
    logic [511:0] exp, got;
    int lat;
    logic [31:0] ew [16] = '{32'he4e7f110, 32'h15593bd1, 32'h1fdd0f50, 32'hc47120a3,
                             32'hc7f4d1c7, 32'h0368c033, 32'h9aaa2204, 32'h4e6cd4c3,
                             32'h466482d2, 32'h09aa9f07, 32'h05d7c214, 32'ha2028bd9,
                             32'hd19c12b5, 32'hb94e16de, 32'he883d0cb, 32'h4e3c50a2};
    for (int i = 0; i < 32; i++) k[8*i +: 8] = 8'(i);
    for (int i = 0; i < 16; i++) exp[32*i +: 32] = ew[i];
    issue(k, {32'h00000000, 32'h4a000000, 32'h09000000}, 32'd1, lat, got);
    chk(got === exp, "R4 R3 published block", got, exp);
    chk(lat == 321, "R6 latency", 512'(lat), 512'(321));
    @(posedge clk); #1;
    chk(!out_valid && in_ready, "R7 drop after take", 512'({out_valid, in_ready}), 512'(1));
  endtask

  task automatic t_model(logic [255:0] k, logic [95:0] n, logic [31:0] ct, string tag);
    logic [511:0] exp, got;
    int lat;
    exp = ref_block(k, n, ct);
    issue(k, n, ct, lat, got);
    chk(got === exp, {"R5 ", tag}, got, exp);
    chk(lat == 321, {"R6 ", tag}, 512'(lat), 512'(321));
    @(posedge clk); #1;
  endtask

  task automatic t_backpressure();
    logic [255:0] k = {8{32'hA5A5_0F0F}};
    logic [511:0] exp, got;
    int lat;
    bit held = 1;
    exp = ref_block(k, 96'h1234_5678_9ABC_DEF0_0BAD_F00D, 32'hFFFF_FFFF);
    out_ready = 1'b0;
    issue(k, 96'h1234_5678_9ABC_DEF0_0BAD_F00D, 32'hFFFF_FFFF, lat, got);
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1;
      if (!out_valid || keystream !== got || in_ready || busy) held = 0;
    end
    chk(held, "R7 hold under back-pressure", 512'(held), 512'(1));
    chk(got === exp, "R5 R7 held block", got, exp);
    @(negedge clk); out_ready = 1'b1;
    @(posedge clk); #1;
    chk(!out_valid && in_ready, "R7 release", 512'({out_valid, in_ready}), 512'(1));
  endtask

  task automatic t_ignore_busy();
    logic [255:0] k = {32'h0BAD_CAFE, 224'h0};
    logic [511:0] exp, got;
    bit busy_ok = 1;
    int lat;
    exp = ref_block(k, 96'h7, 32'h2A);
    @(negedge clk);
    key = k; nonce = 96'h7; blk_ctr = 32'h2A; in_valid = 1'b1;
    @(posedge clk); #1;
    key = ~k; nonce = ~nonce; blk_ctr = 32'h5;
    for (int i = 0; i < 50; i++) begin
      @(posedge clk); #1;
      if (!busy || in_ready) busy_ok = 0;
    end
    in_valid = 1'b0;
    lat = 51;
    while (!out_valid && lat < 1000) begin
      if (!busy || in_ready) busy_ok = 0;
      @(posedge clk); #1 lat++;
    end
    got = keystream;
    chk(busy_ok, "R8 R2 busy and not ready during run", 512'(busy_ok), 512'(1));
    chk(got === exp, "R2 inputs ignored while busy", got, exp);
    chk(!busy, "R8 busy low while holding", 512'(busy), 512'(0));
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1 t_reset();
    t_vector();
    t_model('0, '0, '0, "all zero");
    t_model('1, '1, '1, "all ones carries");
    t_model({8{32'h0123_4567}}, 96'hDEAD_BEEF_0000_0001_8000_0000, 32'h8000_0000, "mixed");
    t_backpressure();
    t_ignore_busy();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule